// File: doc/BRIEF.md
# Quad-Phase Fetch/Execute Sequencer

This block sequences instructions for a small microcontroller core. It splits every instruction cycle into four clock-wide phases, Q1 to Q4. It also overlaps two stages: the word for the next instruction is fetched while the current one executes. A phase generator, a program counter, a fetch latch, an instruction register and an 8-bit accumulator datapath are all driven from these phases. As a result, each action falls on a fixed phase: advancing the address, capturing the fetched word, reading the operand, computing and writing back.

The program-memory port is a synchronous read. The address is the program counter, and the word comes back one clock later. The data-memory port is a single port with a synchronous read strobe and a write strobe. Each instruction word is 12 bits wide. Bits 11:8 hold the opcode and bits 7:0 hold the file address. The opcodes are 0 = no-op, 1 = load file into accumulator, 2 = add file into accumulator, 3 = store accumulator to file, and 4 = add accumulator to file with the sum written back to the file. All other opcodes behave as no-ops.

Top module: `qseq_top`

## Requirements
- R1: `phase` is one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. It holds Q1 in reset and then steps Q1, Q2, Q3, Q4, Q1 on each clock.
- R2: `cyc_start` is high exactly while `phase` is Q1.
- R3: `pmem_addr` changes only on the clock edge that ends Q1, and then it increments by one modulo 256. During Q2 to Q4 of the n-th instruction cycle after reset, it equals n mod 256, starting with n = 0.
- R4: The program word at `pmem_addr` is captured at the end of Q4 and executes in the next instruction cycle. The first cycle after reset executes a no-op, so it has no data-memory strobe and leaves the accumulator at its reset value of 0.
- R5: `dmem_re` is high only during Q2, and only for opcodes 1, 2 and 4. `dmem_addr` then carries bits 7:0 of the executing word.
- R6: `dmem_we` is high only during Q4, and only for opcodes 3 and 4.
- R7: Opcode 1 loads the file value into the accumulator. The accumulator changes only on the edge that ends Q4, so `acc_out` shows the new value from the following Q1.
- R8: Opcode 2 sets the accumulator to the accumulator plus the file value, modulo 256.
- R9: Opcode 3 writes the accumulator to the file. Opcode 4 writes the accumulator plus the file value, modulo 256, to the file and leaves the accumulator unchanged.
- R10: Opcodes 0 and 5 to 15 raise no data-memory strobe and leave the accumulator unchanged.
- R11: One instruction completes every four clocks with no stall. A load that immediately follows a store to the same file reads the newly stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one clock per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | output | 4 | One-hot current phase, bit 0 = Q1 |
| cyc_start | output | 1 | High during Q1 of each instruction cycle |
| pmem_addr | output | 8 | Program-memory address (program counter) |
| pmem_rdata | input | 12 | Program word, valid one clock after the address |
| dmem_addr | output | 8 | Data-memory file address |
| dmem_re | output | 1 | Data-memory read strobe; data returns one clock later |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_wdata | output | 8 | Data-memory write value |
| dmem_rdata | input | 8 | Data-memory read value |
| acc_out | output | 8 | Accumulator |

## Verification
If the phase ring slips, the strobes move to the wrong slot at once. A read outside Q2 or a write outside Q4 becomes visible within the same instruction cycle. A program counter that is off by one, or a fetch latch that is captured too early or too late, executes the wrong word. That error shows up as a wrong `dmem_addr` at the next Q2 or a wrong `acc_out` at the following Q1, at most eight clocks after the fault. A datapath error, such as a missed carry wrap or a write to the wrong destination, appears either on `dmem_wdata` in that instruction's Q4 or on `acc_out` one clock later.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  localparam int QS_PHASES = 4;
  localparam int QS_Q1 = 0;
  localparam int QS_Q2 = 1;
  localparam int QS_Q3 = 2;
  localparam int QS_Q4 = 3;

  localparam logic [3:0] OP_NOP   = 4'h0;
  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_ADD   = 4'h2;
  localparam logic [3:0] OP_STORE = 4'h3;
  localparam logic [3:0] OP_ADDF  = 4'h4;

  // operand is fetched from the file in Q2
  function automatic logic op_reads_file(input logic [3:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_ADDF);
  endfunction

  // result lands in the accumulator at the end of Q4
  function automatic logic op_writes_acc(input logic [3:0] op);
    return (op == OP_LOAD) || (op == OP_ADD);
  endfunction

  // result lands in the file during Q4
  function automatic logic op_writes_file(input logic [3:0] op);
    return (op == OP_STORE) || (op == OP_ADDF);
  endfunction

endpackage

// File: rtl/qseq_phase.sv
module qseq_phase
  import qseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [QS_PHASES-1:0] phase,
  output logic                 cyc_start
);

  logic [QS_PHASES-1:0] ring_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= QS_PHASES'(1);
    else        ring_q <= {ring_q[QS_PHASES-2:0], ring_q[QS_PHASES-1]};
  end

  assign phase     = ring_q;
  assign cyc_start = ring_q[QS_Q1];

endmodule

// File: rtl/qseq_fetch.sv
module qseq_fetch
  import qseq_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [QS_PHASES-1:0] phase,
  input  logic [IW-1:0]        pmem_rdata,
  output logic [AW-1:0]        pc,
  output logic [IW-1:0]        ir
);

  logic [AW-1:0] pc_q;
  logic [IW-1:0] fetch_q;
  logic [IW-1:0] ir_q;

  // pc resets to all-ones so that the first Q1 increment lands on 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '1;
      fetch_q <= '0;
      ir_q    <= '0;
    end else begin
      if (phase[QS_Q1]) begin
        pc_q <= pc_q + AW'(1);
        ir_q <= fetch_q;
      end
      if (phase[QS_Q4]) fetch_q <= pmem_rdata;
    end
  end

  assign pc = pc_q;
  assign ir = ir_q;

endmodule

// File: rtl/qseq_exec.sv
module qseq_exec
  import qseq_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 8,
  parameter int IW  = 12,
  parameter int OPW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [QS_PHASES-1:0] phase,
  input  logic [IW-1:0]        ir,
  output logic [AW-1:0]        dmem_addr,
  output logic                 dmem_re,
  output logic                 dmem_we,
  output logic [DW-1:0]        dmem_wdata,
  input  logic [DW-1:0]        dmem_rdata,
  output logic [DW-1:0]        acc
);

  logic [OPW-1:0] op;
  logic [DW-1:0]  acc_q;
  logic [DW-1:0]  res_q;

  function automatic logic [DW-1:0] alu(input logic [OPW-1:0] o,
                                        input logic [DW-1:0] a,
                                        input logic [DW-1:0] f);
    case (o)
      OP_LOAD:         return f;
      OP_ADD, OP_ADDF: return a + f;
      default:         return a;
    endcase
  endfunction

  assign op        = ir[IW-1 -: OPW];
  assign dmem_addr = ir[AW-1:0];
  assign dmem_re   = phase[QS_Q2] & op_reads_file(op);
  assign dmem_we   = phase[QS_Q4] & op_writes_file(op);
  assign dmem_wdata = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (phase[QS_Q3]) res_q <= alu(op, acc_q, dmem_rdata);
      if (phase[QS_Q4] && op_writes_acc(op)) acc_q <= res_q;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 8,
  parameter int OPW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [3:0]        phase,
  output logic              cyc_start,
  output logic [AW-1:0]     pmem_addr,
  input  logic [OPW+AW-1:0] pmem_rdata,
  output logic [AW-1:0]     dmem_addr,
  output logic              dmem_re,
  output logic              dmem_we,
  output logic [DW-1:0]     dmem_wdata,
  input  logic [DW-1:0]     dmem_rdata,
  output logic [DW-1:0]     acc_out
);

  localparam int IW = OPW + AW;

  logic [IW-1:0] ir_word;

  qseq_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .cyc_start (cyc_start)
  );

  qseq_fetch #(.AW(AW), .IW(IW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .pmem_rdata (pmem_rdata),
    .pc         (pmem_addr),
    .ir         (ir_word)
  );

  qseq_exec #(.AW(AW), .DW(DW), .IW(IW), .OPW(OPW)) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .ir         (ir_word),
    .dmem_addr  (dmem_addr),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .acc        (acc_out)
  );

endmodule

// File: rtl/qseq_chk.sv
module qseq_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int IW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    phase,
  input logic          cyc_start,
  input logic [AW-1:0] pmem_addr,
  input logic          dmem_re,
  input logic          dmem_we,
  input logic [DW-1:0] acc_out,
  input logic [IW-1:0] ir_word
);

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1); // R1
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    phase[3] |=> phase[0]); // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] |=> phase[1]); // R1
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start); // R2
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[0] |=> $stable(pmem_addr)); // R3
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] |=> pmem_addr == AW'($past(pmem_addr) + 1'b1)); // R3
  AST_IR_LOAD_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[0] |=> $stable(ir_word)); // R4
  AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |-> phase[1]); // R5
  AST_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> phase[3]); // R6
  AST_ACC_Q4_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[3] |=> $stable(acc_out)); // R7

endmodule

bind qseq_top qseq_chk #(.AW(AW), .DW(DW), .IW(OPW + AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase),
  .cyc_start (cyc_start),
  .pmem_addr (pmem_addr),
  .dmem_re   (dmem_re),
  .dmem_we   (dmem_we),
  .acc_out   (acc_out),
  .ir_word   (ir_word)
);

// File: tb/tb_qseq_top.sv
module tb_qseq_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPROG = 17;

  typedef struct {
    bit         re;
    bit         we;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] acc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  phase;
  logic        cyc_start;
  logic [7:0]  pmem_addr;
  logic [11:0] pmem_rdata = '0;
  logic [7:0]  dmem_addr;
  logic        dmem_re;
  logic        dmem_we;
  logic [7:0]  dmem_wdata;
  logic [7:0]  dmem_rdata = '0;
  logic [7:0]  acc_out;

  logic [11:0] prog [256];
  logic [7:0]  dm   [256];
  logic [7:0]  mdl  [256];
  exp_t        expq [$];

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  bit  reported = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qseq_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .cyc_start  (cyc_start),
    .pmem_addr  (pmem_addr),
    .pmem_rdata (pmem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .acc_out    (acc_out)
  );

  // memory models
  always @(posedge clk) begin
    pmem_rdata <= prog[pmem_addr];
    if (dmem_re) dmem_rdata <= dm[dmem_addr];
    if (dmem_we) dm[dmem_addr] <= dmem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: build program, model it, push expected items
  task automatic drive_program();
    logic [11:0] words [NPROG];
    logic [7:0]  acc;
    words = '{12'h10A, 12'h214, 12'h328, 12'h128, 12'h005, 12'h91E,
              12'h40A, 12'h10A, 12'hF00, 12'h2FF, 12'h300, 12'h200,
              12'h1FF, 12'h2FF, 12'h3FF, 12'h4FF, 12'h1FF};
    for (int i = 0; i < 256; i++) begin
      prog[i] = '0;
      dm[i]   = 8'((i * 7 + 3) & 255);
      mdl[i]  = dm[i];
    end
    for (int i = 0; i < NPROG; i++) prog[i] = words[i];
    acc = '0;
    for (int i = 0; i < NPROG; i++) begin
      exp_t e;
      logic [3:0] op;
      logic [7:0] a;
      op = words[i][11:8];
      a  = words[i][7:0];
      e.re = 0; e.we = 0; e.addr = a; e.wdata = '0;
      case (op)
        4'h1: begin e.re = 1; acc = mdl[a]; end
        4'h2: begin e.re = 1; acc = acc + mdl[a]; end
        4'h3: begin e.we = 1; e.wdata = acc; mdl[a] = acc; end
        4'h4: begin e.re = 1; e.we = 1; e.wdata = acc + mdl[a]; mdl[a] = e.wdata; end
        default: ;
      endcase
      e.acc = acc;
      expq.push_back(e);
    end
  endtask

  // monitor: compare ports each clock, half a period after the edge
  initial begin : monitor
    int   cyc;
    int   k;
    exp_t cur;
    cyc = -1;
    k = 0;
    cur = '{re: 0, we: 0, addr: '0, wdata: '0, acc: '0};
    wait (rst_n);
    forever begin
      #1;
      chk(phase == 4'(1 << (k % 4)), "R1", "phase", phase, 1 << (k % 4));
      chk(cyc_start == (k % 4 == 0), "R2", "cyc_start", cyc_start, k % 4 == 0);
      case (k % 4)
        0: begin
          cyc++;
          if (cyc == 0) begin
            chk(acc_out == 0, "R4", "reset acc", acc_out, 0);
            chk(dmem_we == 0, "R4", "reset we", dmem_we, 0);
          end else if (cyc == 1) begin
            chk(acc_out == 0, "R4", "acc after first no-op", acc_out, 0);
          end else begin
            chk(acc_out == cur.acc, "R7 R8 R10 R11", "acc", acc_out, cur.acc);
          end
          if (cyc == NPROG + 3) begin
            done = 1'b1;
            break;
          end
        end
        1: begin
          if (cyc == 0) begin
            chk(dmem_re == 0, "R4", "first-cycle read", dmem_re, 0);
          end else begin
            if (expq.size() > 0) cur = expq.pop_front();
            else begin cur.re = 0; cur.we = 0; end
            chk(dmem_re == cur.re, "R5", "read strobe", dmem_re, cur.re);
            if (cur.re) chk(dmem_addr == cur.addr, "R5", "read addr", dmem_addr, cur.addr);
          end
        end
        2: begin
          chk(!dmem_re && !dmem_we, "R5 R6", "strobe in Q3", {dmem_re, dmem_we}, 0);
        end
        default: begin
          chk(pmem_addr == 8'(cyc), "R3", "fetch address", pmem_addr, cyc & 255);
          if (cyc == 0) begin
            chk(dmem_we == 0, "R4", "first-cycle write", dmem_we, 0);
          end else begin
            chk(dmem_we == cur.we, "R6", "write strobe", dmem_we, cur.we);
            if (cur.we) begin
              chk(dmem_addr == cur.addr, "R9", "write addr", dmem_addr, cur.addr);
              chk(dmem_wdata == cur.wdata, "R9", "write data", dmem_wdata, cur.wdata);
            end
          end
        end
      endcase
      k++;
      @(negedge clk);
    end
  end

  initial begin : main
    drive_program();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait (done);
    chk(dm[40] == mdl[40], "R9 R11", "stored file 40", dm[40], mdl[40]);
    chk(dm[255] == mdl[255], "R9", "file 255 after add-to-file", dm[255], mdl[255]);
    summary();
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

endmodule